// File: doc/BRIEF.md
# Two-Product Coin Vending Controller

This block is the control core of a drink dispenser that takes two coin sizes (50 and 100 units) and sells two drinks, a small one at 100 units and a large one at 200 units. It keeps the customer's credit as its only state, counted in steps of 50 units from 0 to 300. Coin and button inputs are expected to arrive already debounced, each as a single-cycle pulse. The block answers with one-cycle pulses that dispense a drink, reject a coin, or pay back the whole credit.

All outputs are registered. The response to the inputs sampled on a rising clock edge appears right after that edge and lasts one cycle. After a purchase, any remaining credit stays in the machine for further purchases. Only the return button gives credit back. The refund is reported as a count of 50-unit coins.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is low and after it is released, every output is low, `refund_coins` is 0 and the credit is 0 (a return press then reports a count of 0).
- R2: When no button is pressed, a 50-unit coin adds one 50-unit step to the credit and a 100-unit coin adds two steps, provided the new total is at most 300.
- R3: A coin that would raise the credit above 300 is refused: `coin_reject` pulses and the credit is unchanged, so the credit never exceeds 300.
- R4: A small-drink request with credit of at least 100 pulses `vend_small` and lowers the credit by 100.
- R5: A large-drink request with credit of at least 200 pulses `vend_large` and lowers the credit by 200.
- R6: A drink request with too little credit is ignored: no vend pulse is produced and the credit is unchanged.
- R7: A return press pulses `refund` and clears the credit to 0. During that pulse, `refund_coins` carries the credit held before the press as a count of 50-unit coins. `refund_coins` is 0 whenever `refund` is low.
- R8: Among buttons pressed in the same cycle, return wins over the large drink, and the large drink wins over the small drink. Only the winning button is acted on, even if its request is then ignored under R6.
- R9: A coin present in the same cycle as any button press is not credited, and `coin_reject` pulses.
- R10: If both coins arrive in the same cycle with no button pressed, the 100-unit coin is handled alone under R2 and R3, and the 50-unit coin is refused with a `coin_reject` pulse.
- R11: Each output pulse appears in the cycle after the inputs are sampled and lasts one cycle. At most one of `vend_small`, `vend_large` and `refund` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coin_lo | input | 1 | One-cycle pulse: 50-unit coin inserted |
| coin_hi | input | 1 | One-cycle pulse: 100-unit coin inserted |
| buy_small | input | 1 | Request for the 100-unit drink |
| buy_large | input | 1 | Request for the 200-unit drink |
| ret_btn | input | 1 | Return button: refund all credit |
| vend_small | output | 1 | One-cycle pulse dispensing the 100-unit drink |
| vend_large | output | 1 | One-cycle pulse dispensing the 200-unit drink |
| refund | output | 1 | One-cycle pulse paying back the credit |
| refund_coins | output | 3 | Refund as a count of 50-unit coins, valid while `refund` is high |
| coin_reject | output | 1 | One-cycle pulse: a coin was refused |

## Verification
The bench loads every reachable credit level (0 through 300 in 50-unit steps). At each level it applies all 32 combinations of the five inputs, then reads the credit back with a return press. Single inputs check the arithmetic of coins and purchases and where the ceiling and the prices take effect. Combined inputs check the priority order, the refusal of coins that arrive with a button press, and the rule for two coins at once. An idle cycle after each stimulus confirms that every pulse lasts one cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_REFUND  = 3'd1,
    ACT_BUY_HI  = 3'd2,
    ACT_BUY_LO  = 3'd3,
    ACT_COIN_HI = 3'd4,
    ACT_COIN_LO = 3'd5
  } vend_act_e;

  // true when adding 'add' steps keeps the credit within 'cap' steps
  function automatic logic coin_fits(input int unsigned credit,
                                     input int unsigned add,
                                     input int unsigned cap);
    return (credit + add) <= cap;
  endfunction

  // true when the credit covers a price given in steps
  function automatic logic can_afford(input int unsigned credit,
                                      input int unsigned price);
    return credit >= price;
  endfunction

endpackage

// File: rtl/vend_decode.sv
module vend_decode
  import vend_pkg::*;
(
  input  logic      coin_lo,
  input  logic      coin_hi,
  input  logic      buy_small,
  input  logic      buy_large,
  input  logic      ret_btn,
  output vend_act_e act,
  output logic      coin_any,
  output logic      coin_both
);

  always_comb begin
    if (ret_btn)        act = ACT_REFUND;
    else if (buy_large) act = ACT_BUY_HI;
    else if (buy_small) act = ACT_BUY_LO;
    else if (coin_hi)   act = ACT_COIN_HI;
    else if (coin_lo)   act = ACT_COIN_LO;
    else                act = ACT_IDLE;
  end

  assign coin_any  = coin_lo | coin_hi;
  assign coin_both = coin_lo & coin_hi;

  // R8: return always wins when pressed
  always_comb begin
    a_r8_return_first: assert (!ret_btn || act == ACT_REFUND);
  end

endmodule

// File: rtl/vend_credit.sv
module vend_credit
  import vend_pkg::*;
#(
  parameter int unsigned CAP_STEPS     = 6,
  parameter int unsigned COIN_HI_STEPS = 2,
  parameter int unsigned COIN_LO_STEPS = 1,
  parameter int unsigned PRICE_HI      = 4,
  parameter int unsigned PRICE_LO      = 2,
  localparam int unsigned CW = $clog2(CAP_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vend_act_e     act,
  input  logic          coin_any,
  input  logic          coin_both,
  output logic [CW-1:0] credit_q,
  output logic          ev_vend_hi,
  output logic          ev_vend_lo,
  output logic          ev_refund,
  output logic          ev_reject
);

  localparam logic [CW-1:0] P_HI = CW'(PRICE_HI);
  localparam logic [CW-1:0] P_LO = CW'(PRICE_LO);
  localparam logic [CW-1:0] C_HI = CW'(COIN_HI_STEPS);
  localparam logic [CW-1:0] C_LO = CW'(COIN_LO_STEPS);

  logic [CW-1:0] credit_d;
  int unsigned   cur;

  assign cur = 32'(credit_q);

  always_comb begin
    credit_d   = credit_q;
    ev_vend_hi = 1'b0;
    ev_vend_lo = 1'b0;
    ev_refund  = 1'b0;
    ev_reject  = 1'b0;
    unique case (act)
      ACT_REFUND: begin
        ev_refund = 1'b1;
        credit_d  = '0;
        ev_reject = coin_any;
      end
      ACT_BUY_HI: begin
        ev_reject = coin_any;
        if (can_afford(cur, PRICE_HI)) begin
          ev_vend_hi = 1'b1;
          credit_d   = credit_q - P_HI;
        end
      end
      ACT_BUY_LO: begin
        ev_reject = coin_any;
        if (can_afford(cur, PRICE_LO)) begin
          ev_vend_lo = 1'b1;
          credit_d   = credit_q - P_LO;
        end
      end
      ACT_COIN_HI: begin
        if (coin_fits(cur, COIN_HI_STEPS, CAP_STEPS)) begin
          credit_d  = credit_q + C_HI;
          ev_reject = coin_both;
        end else begin
          ev_reject = 1'b1;
        end
      end
      ACT_COIN_LO: begin
        if (coin_fits(cur, COIN_LO_STEPS, CAP_STEPS)) credit_d = credit_q + C_LO;
        else                                          ev_reject = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= '0;
    else        credit_q <= credit_d;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(credit_q) <= CAP_STEPS);

  a_r4_small_price: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vend_lo |=> credit_q == $past(credit_q) - P_LO);

  a_r5_large_price: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vend_hi |=> credit_q == $past(credit_q) - P_HI);

  a_r7_refund_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refund |=> credit_q == '0);

  a_r6_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((act == ACT_BUY_HI || act == ACT_BUY_LO) && !ev_vend_hi && !ev_vend_lo)
      |=> $stable(credit_q));

  a_r9_button_coin_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (act inside {ACT_REFUND, ACT_BUY_HI, ACT_BUY_LO} && coin_any) |-> ev_reject);

endmodule

// File: rtl/vend_outreg.sv
module vend_outreg #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_vend_hi,
  input  logic          ev_vend_lo,
  input  logic          ev_refund,
  input  logic          ev_reject,
  input  logic [CW-1:0] credit_now,
  output logic          vend_large,
  output logic          vend_small,
  output logic          refund,
  output logic [CW-1:0] refund_coins,
  output logic          coin_reject
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vend_large   <= 1'b0;
      vend_small   <= 1'b0;
      refund       <= 1'b0;
      refund_coins <= '0;
      coin_reject  <= 1'b0;
    end else begin
      vend_large   <= ev_vend_hi;
      vend_small   <= ev_vend_lo;
      refund       <= ev_refund;
      refund_coins <= ev_refund ? credit_now : '0;
      coin_reject  <= ev_reject;
    end
  end

  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vend_large, vend_small, refund}));

  a_r7_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !refund |-> refund_coins == '0);

  a_r7_count_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refund |=> refund_coins == $past(credit_now));

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned CAP_STEPS     = 6,
  parameter int unsigned COIN_HI_STEPS = 2,
  parameter int unsigned COIN_LO_STEPS = 1,
  parameter int unsigned PRICE_HI      = 4,
  parameter int unsigned PRICE_LO      = 2,
  localparam int unsigned CW = $clog2(CAP_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coin_lo,
  input  logic          coin_hi,
  input  logic          buy_small,
  input  logic          buy_large,
  input  logic          ret_btn,
  output logic          vend_small,
  output logic          vend_large,
  output logic          refund,
  output logic [CW-1:0] refund_coins,
  output logic          coin_reject
);

  vend_act_e     act;
  logic          coin_any, coin_both;
  logic [CW-1:0] credit_q;
  logic          ev_vend_hi, ev_vend_lo, ev_refund, ev_reject;

  vend_decode u_decode (
    .coin_lo   (coin_lo),
    .coin_hi   (coin_hi),
    .buy_small (buy_small),
    .buy_large (buy_large),
    .ret_btn   (ret_btn),
    .act       (act),
    .coin_any  (coin_any),
    .coin_both (coin_both)
  );

  vend_credit #(
    .CAP_STEPS     (CAP_STEPS),
    .COIN_HI_STEPS (COIN_HI_STEPS),
    .COIN_LO_STEPS (COIN_LO_STEPS),
    .PRICE_HI      (PRICE_HI),
    .PRICE_LO      (PRICE_LO)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .coin_any   (coin_any),
    .coin_both  (coin_both),
    .credit_q   (credit_q),
    .ev_vend_hi (ev_vend_hi),
    .ev_vend_lo (ev_vend_lo),
    .ev_refund  (ev_refund),
    .ev_reject  (ev_reject)
  );

  vend_outreg #(.CW(CW)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_vend_hi   (ev_vend_hi),
    .ev_vend_lo   (ev_vend_lo),
    .ev_refund    (ev_refund),
    .ev_reject    (ev_reject),
    .credit_now   (credit_q),
    .vend_large   (vend_large),
    .vend_small   (vend_small),
    .refund       (refund),
    .refund_coins (refund_coins),
    .coin_reject  (coin_reject)
  );

  // R10: two coins at once always produce a refusal
  a_r10_double_coin: assert property (@(posedge clk) disable iff (!rst_n)
    (coin_lo && coin_hi) |=> coin_reject);

endmodule

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coin_lo = 0, coin_hi = 0, buy_small = 0, buy_large = 0, ret_btn = 0;
  logic       vend_small, vend_large, refund, coin_reject;
  logic [2:0] refund_coins;

  int checks = 0;
  int errors = 0;
  int credit = 0;   // bench model, in money units
  bit done = 0;

  always #2.5 clk = ~clk;

  vend_ctrl i_vend_ctrl (
    .clk(clk), .rst_n(rst_n),
    .coin_lo(coin_lo), .coin_hi(coin_hi),
    .buy_small(buy_small), .buy_large(buy_large), .ret_btn(ret_btn),
    .vend_small(vend_small), .vend_large(vend_large),
    .refund(refund), .refund_coins(refund_coins), .coin_reject(coin_reject)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (credit %0d)", req, act, exp, credit);
    end
  endtask

  // drive one cycle of inputs, then compare the registered response
  task automatic apply(input bit r, input bit bl, input bit bs, input bit ch, input bit cl);
    bit e_vl = 0, e_vs = 0, e_rf = 0, e_rj = 0;
    int e_cnt = 0;
    string tag;
    @(negedge clk);
    ret_btn = r; buy_large = bl; buy_small = bs; coin_hi = ch; coin_lo = cl;
    if (r) begin
      e_rf = 1; e_cnt = credit / 50; e_rj = ch | cl; credit = 0; tag = "R7/R8";
    end else if (bl) begin
      e_rj = ch | cl; tag = "R5/R6/R9";
      if (credit >= 200) begin e_vl = 1; credit -= 200; end
    end else if (bs) begin
      e_rj = ch | cl; tag = "R4/R6/R9";
      if (credit >= 100) begin e_vs = 1; credit -= 100; end
    end else if (ch) begin
      tag = "R2/R3/R10";
      if (credit + 100 <= 300) begin credit += 100; e_rj = cl; end
      else e_rj = 1;
    end else if (cl) begin
      tag = "R2/R3";
      if (credit + 50 <= 300) credit += 50;
      else e_rj = 1;
    end else tag = "R11";
    @(posedge clk); #1;
    check({tag, " vend_large"}, vend_large, e_vl);
    check({tag, " vend_small"}, vend_small, e_vs);
    check({tag, " refund"}, refund, e_rf);
    check({tag, " refund_coins"}, refund_coins, e_cnt);
    check({tag, " coin_reject"}, coin_reject, e_rj);
    @(negedge clk);
    ret_btn = 0; buy_large = 0; buy_small = 0; coin_hi = 0; coin_lo = 0;
  endtask

  task automatic load(input int target);
    apply(1, 0, 0, 0, 0);
    for (int k = 0; k < target / 100; k++) apply(0, 0, 0, 1, 0);
    if (target % 100 != 0) apply(0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    check("R1 reset vend_large", vend_large, 0);
    check("R1 reset vend_small", vend_small, 0);
    check("R1 reset refund", refund, 0);
    check("R1 reset coin_reject", coin_reject, 0);
    @(negedge clk); rst_n = 1;
    // R1: credit starts at zero, a return reports zero coins
    apply(1, 0, 0, 0, 0);
    // R3: fill to the ceiling one 50 at a time, then overflow attempts
    for (int k = 0; k < 7; k++) apply(0, 0, 0, 0, 1);
    apply(0, 0, 0, 1, 0);
    // R4, R5: consecutive purchases with leftover credit
    apply(0, 0, 1, 0, 0);
    apply(0, 1, 0, 0, 0);
    apply(0, 1, 0, 0, 0);
    apply(1, 0, 0, 0, 0);
    // exhaustive: every credit level against every input combination
    for (int lvl = 0; lvl <= 300; lvl += 50) begin
      for (int combo = 0; combo < 32; combo++) begin
        load(lvl);
        apply(combo[4], combo[3], combo[2], combo[1], combo[0]);
        apply(0, 0, 0, 0, 0);   // R11: pulses last one cycle
        apply(1, 0, 0, 0, 0);   // read back credit via refund count
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule